// File: doc/BRIEF.md
# Binary Code Modulation LED Driver

This block dims 32 LED channels (eight four-colour groups of four channels) by binary code modulation through an external chain of serial-in, parallel-out shift registers. A host writes 16-bit brightness words into a 32-entry register file. Only the upper 14 bits of each word count. The block regroups the stored values into 14 bit planes of 32 bits, where each plane holds one bit weight of every channel. It then plays the planes in turn. For each plane it shifts the 32 bits out, latches them onto the outputs with a one-tick strobe, and holds them for a time proportional to the plane's weight. A short reset interval then follows, and it ends with a one-tick active-low clear.

Each bit period has two parts. The data cycle is the shift, then the strobe at a fixed tick, then the weighted hold. The reset cycle is a short fixed interval that ends with the clear. The length of the next cycle is loaded only at the boundary of the current one, so every frame has the same length. Newly written values are used only from the next frame start, so a frame never mixes old and new data.

Top module: `bcm_led_driver`

## Requirements
- R1: In plane i, the bit for channel j equals bit (i + WORD_W - DEPTH) of the last brightness word written to address j.
- R2: The two low bits of a brightness word (bits 1:0 for the defaults) never affect any shifted plane bit.
- R3: Each plane is sent as exactly 32 rising edges of `sclk`, with `sclk` idle low and `sdo` set up while `sclk` is low. The order is channel 15 down to channel 0, then channel 31 down to channel 16.
- R4: `strobe` is a one-tick pulse that comes SHIFT_TICKS - 1 ticks after the plane's first `sclk` rise, while `sclk` is low.
- R5: From the strobe of plane i to the following clear is (BASE_TICKS << i) + RST_TICKS - 1 ticks.
- R6: `clr_n` goes low for exactly one tick, once per bit period, at the last tick of the reset cycle, and never together with `strobe`.
- R7: Planes are played in the order 0, 1, ..., DEPTH-1 and then wrap to 0. From the strobe of plane i to the next strobe is SHIFT_TICKS + (BASE_TICKS << i) + RST_TICKS ticks.
- R8: A write during a frame does not change the planes still to be played in that frame. It shows from the next plane 0 onward.
- R9: While `rst_n` is low and on the tick after it: `sdo`=0, `sclk`=0, `strobe`=0 and `clr_n`=1. After reset all brightness values are zero, and the first frame starts at plane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulation clock, one tick per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the brightness register file |
| wr_addr | input | ADDR_W (5) | Channel number to write |
| wr_data | input | WORD_W (16) | Brightness word, upper DEPTH bits used |
| sdo | output | 1 | Serial data to the shift-register chain |
| sclk | output | 1 | Shift clock, idle low |
| strobe | output | 1 | Storage latch pulse |
| clr_n | output | 1 | Active-low clear pulse |

## Verification
Every output is registered once after the counter that decodes it, so a timing check compares two outputs with each other and is not affected by that common lag. Strobe, clear and `sclk` edges are timed in whole ticks from the previous strobe. The expected spacing follows from R4, R5 and R7 for the plane index, and the bench derives that index by counting strobes since reset. Brightness changes are due one frame boundary after they are written, so the bench takes a copy of its model at each plane-0 strobe and compares every captured plane against that copy. All outputs are sampled on the falling edge.

// File: rtl/bcm_pkg.sv
// Shared types for the binary code modulation driver.
// Assumes nothing beyond a single clock domain.
package bcm_pkg;
    // Which part of a bit period is running.
    typedef enum logic {
        PH_DATA  = 1'b0,
        PH_RESET = 1'b1
    } phase_t;
endpackage

// File: rtl/bcm_regfile.sv
// Brightness register file with transposed plane view.
// Stores only the upper DEPTH bits of each word and presents them regrouped
// by bit weight. Assumes wr_addr < NCH.
module bcm_regfile #(
    parameter int NCH    = 32,
    parameter int WORD_W = 16,
    parameter int DEPTH  = 14,
    parameter int ADDR_W = $clog2(NCH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [DEPTH-1:0][NCH-1:0]  pend_planes
);
    logic [DEPTH-1:0] level [NCH];

    // Capture the used bits of a written word; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) level[c] <= '0;
        end else if (wr_en) begin
            level[wr_addr] <= wr_data[WORD_W-1 -: DEPTH];
        end
    end

    // Regroup stored levels into one word per bit weight.
    for (genvar i = 0; i < DEPTH; i++) begin : g_plane
        for (genvar j = 0; j < NCH; j++) begin : g_chan
            assign pend_planes[i][j] = level[j][i];
        end
    end
endmodule

// File: rtl/bcm_sequencer.sv
// Period sequencer: walks plane indices and alternates data and reset cycles.
// The length of the next cycle is loaded only at the current boundary.
// Assumes SHIFT_TICKS exceeds the shift time and RST_TICKS >= 1.
module bcm_sequencer
    import bcm_pkg::*;
#(
    parameter int DEPTH       = 14,
    parameter int SHIFT_TICKS = 72,
    parameter int BASE_TICKS  = 16,
    parameter int RST_TICKS   = 4,
    parameter int LEN_W       = 20,
    parameter int IDX_W       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    output phase_t            phase,
    output logic [IDX_W-1:0]  idx,
    output logic [LEN_W-1:0]  cnt,
    output logic              last,
    output logic              frame_load
);
    logic [LEN_W-1:0] cur_len;
    logic [IDX_W-1:0] nxt_idx;

    // Data-cycle length for a given plane index.
    function automatic logic [LEN_W-1:0] data_len(input logic [IDX_W-1:0] i);
        return LEN_W'(SHIFT_TICKS) + (LEN_W'(BASE_TICKS) << i);
    endfunction

    // Boundary detection and the index that follows.
    always_comb begin
        last       = (cnt == cur_len - LEN_W'(1));
        nxt_idx    = (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + IDX_W'(1);
        frame_load = last && (phase == PH_RESET) && (nxt_idx == '0);
    end

    // Tick counter, phase and preloaded length update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_DATA;
            idx     <= '0;
            cnt     <= '0;
            cur_len <= data_len('0);
        end else if (last) begin
            cnt <= '0;
            if (phase == PH_DATA) begin
                phase   <= PH_RESET;
                cur_len <= LEN_W'(RST_TICKS);
            end else begin
                phase   <= PH_DATA;
                idx     <= nxt_idx;
                cur_len <= data_len(nxt_idx);
            end
        end else begin
            cnt <= cnt + LEN_W'(1);
        end
    end

    // R7
    // A reset cycle is always followed by a fresh data cycle.
    reset_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESET && last) |=> (phase == PH_DATA && cnt == '0));

    // R8
    // New planes are taken only as plane 0 begins.
    load_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> (idx == '0 && phase == PH_DATA));
endmodule

// File: rtl/bcm_shifter.sv
// Output stage: serialises the current plane and decodes strobe and clear.
// All outputs are registered. Bit order is low half first, MSB first within
// each half, with two ticks per bit (low then high clock phase).
module bcm_shifter
    import bcm_pkg::*;
#(
    parameter int NCH         = 32,
    parameter int LEN_W       = 20,
    parameter int SHIFT_TICKS = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic [LEN_W-1:0]  cnt,
    input  logic              last,
    input  logic [NCH-1:0]    plane,
    output logic              sdo,
    output logic              sclk,
    output logic              strobe,
    output logic              clr_n
);
    localparam int HALF  = NCH / 2;
    localparam int POS_W = $clog2(NCH);

    logic             sdo_d, sclk_d, strobe_d, clr_n_d;
    logic [POS_W-1:0] pos;
    int               k;

    // Pick the bit for the current tick and decode the pulses.
    always_comb begin
        k        = 0;
        pos      = '0;
        sdo_d    = 1'b0;
        sclk_d   = 1'b0;
        if (phase == PH_DATA && cnt < LEN_W'(2 * NCH)) begin
            k      = int'(cnt >> 1);
            pos    = (k < HALF) ? POS_W'(HALF - 1 - k) : POS_W'(NCH - 1 - (k - HALF));
            sdo_d  = plane[pos];
            sclk_d = cnt[0];
        end
        strobe_d = (phase == PH_DATA) && (cnt == LEN_W'(SHIFT_TICKS));
        clr_n_d  = !((phase == PH_RESET) && last);
    end

    // Register the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo    <= 1'b0;
            sclk   <= 1'b0;
            strobe <= 1'b0;
            clr_n  <= 1'b1;
        end else begin
            sdo    <= sdo_d;
            sclk   <= sclk_d;
            strobe <= strobe_d;
            clr_n  <= clr_n_d;
        end
    end

    // R4
    // The latch pulse lands with the shift clock at rest.
    strobe_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !sclk);

    // R4
    // The latch pulse lasts one tick.
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R6
    // The clear pulse lasts one tick.
    clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> clr_n);

    // R6
    // Clear and latch never overlap.
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && !clr_n));
endmodule

// File: rtl/bcm_led_driver.sv
// Binary code modulation LED driver top.
// Holds brightness, double-buffers the bit planes at frame start and drives
// an external shift-register chain. One modulation tick per clk cycle.
module bcm_led_driver
    import bcm_pkg::*;
#(
    parameter int NCH         = 32,
    parameter int WORD_W      = 16,
    parameter int DEPTH       = 14,
    parameter int SHIFT_TICKS = 72,
    parameter int BASE_TICKS  = 16,
    parameter int RST_TICKS   = 4,
    parameter int ADDR_W      = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              sdo,
    output logic              sclk,
    output logic              strobe,
    output logic              clr_n
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LEN_W = $clog2(SHIFT_TICKS + (BASE_TICKS << (DEPTH - 1)) + RST_TICKS + 1);

    logic [DEPTH-1:0][NCH-1:0] pend_planes;
    logic [DEPTH-1:0][NCH-1:0] active;
    phase_t                    phase;
    logic [IDX_W-1:0]          idx;
    logic [LEN_W-1:0]          cnt;
    logic                      last;
    logic                      frame_load;

    bcm_regfile #(.NCH(NCH), .WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pend_planes(pend_planes)
    );

    bcm_sequencer #(.DEPTH(DEPTH), .SHIFT_TICKS(SHIFT_TICKS), .BASE_TICKS(BASE_TICKS),
                    .RST_TICKS(RST_TICKS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .phase(phase), .idx(idx), .cnt(cnt),
        .last(last), .frame_load(frame_load)
    );

    // Swap in the pending planes only as a new frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n)          active <= '0;
        else if (frame_load) active <= pend_planes;
    end

    bcm_shifter #(.NCH(NCH), .LEN_W(LEN_W), .SHIFT_TICKS(SHIFT_TICKS)) u_out (
        .clk(clk), .rst_n(rst_n), .phase(phase), .cnt(cnt), .last(last),
        .plane(active[idx]), .sdo(sdo), .sclk(sclk), .strobe(strobe), .clr_n(clr_n)
    );

    // R8
    // The played planes change only on a frame load.
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> $stable(active));
endmodule

// File: tb/bcm_led_driver_tb.sv
module bcm_led_driver_tb;
    localparam int NCH = 32, WORD_W = 16, DEPTH = 14;
    localparam int SHIFT = 72, BASE = 1, RST = 4;
    localparam int LSB_OFF = WORD_W - DEPTH;
    localparam int NVEC = 4;
    localparam logic [15:0] V_BASE [NVEC] = '{16'hFFFF, 16'hA5A5, 16'h0000, 16'hFFFF};
    localparam logic [15:0] V_MUL  [NVEC] = '{16'h0000, 16'h1357, 16'h0204, 16'h0001};
    localparam logic [15:0] V_MASK [NVEC] = '{16'hFFFF, 16'hFFFF, 16'hFFFC, 16'h0003};

    logic clk = 0, rst_n = 0, wr_en = 0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic sdo, sclk, strobe, clr_n;

    always #4 clk = ~clk;

    bcm_led_driver #(.NCH(NCH), .WORD_W(WORD_W), .DEPTH(DEPTH), .SHIFT_TICKS(SHIFT),
                     .BASE_TICKS(BASE), .RST_TICKS(RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdo), .sclk(sclk), .strobe(strobe), .clr_n(clr_n));

    int checks = 0, failures = 0;
    logic [15:0] model [NCH];
    int cur_vec = -1, write_frame = -1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] vval(input int v, input int ch);
        return (V_BASE[v] ^ (V_MUL[v] * 16'(ch))) & V_MASK[v];
    endfunction

    // Monitor state
    int cyc = 0, strobes = 0, nbits = 0, last_stb = 0, rise_cyc = 0, clears = 0;
    int plane = 0, snap_vec = -1;
    logic prev_sclk = 0, prev_clr = 1, prev_stb = 0;
    logic [31:0] shr = '0;
    logic [15:0] snap [NCH];

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            strobes = 0; nbits = 0; clears = 0; prev_sclk = 0; prev_clr = 1; prev_stb = 0;
        end else begin
            if (sclk && !prev_sclk) begin
                shr = {shr[30:0], sdo};
                nbits++;
                if (nbits == 1) rise_cyc = cyc;
            end
            if (strobe && !prev_stb) begin
                logic [31:0] got, exp;
                string tag;
                int frame;
                if (strobes > 0) begin
                    chk(cyc - last_stb == SHIFT + (BASE << plane) + RST, "R7", "strobe spacing",
                        cyc - last_stb, SHIFT + (BASE << plane) + RST);
                    chk(clears == 1, "R6", "clears per period", clears, 1);
                end
                plane = strobes % DEPTH;
                frame = strobes / DEPTH;
                if (plane == 0) begin
                    for (int j = 0; j < NCH; j++) snap[j] = model[j];
                    snap_vec = cur_vec;
                end
                got = {shr[15:0], shr[31:16]};
                for (int j = 0; j < NCH; j++) exp[j] = snap[j][LSB_OFF + plane];
                if (frame == 0)                              tag = "R9";
                else if (snap_vec == 3)                      tag = "R2";
                else if (frame == write_frame && plane >= 2) tag = "R8";
                else                                         tag = "R1";
                chk(got == exp, tag, $sformatf("plane %0d data", plane), got, exp);
                chk(nbits == 32, "R3", "sclk rises per plane", nbits, 32);
                chk(cyc - rise_cyc == SHIFT - 1, "R4", "strobe after first rise",
                    cyc - rise_cyc, SHIFT - 1);
                nbits = 0; clears = 0; last_stb = cyc; strobes++;
            end else if (strobe) begin
                chk(0, "R4", "strobe width", 2, 1);
            end
            if (!clr_n) begin
                clears++;
                chk(cyc - last_stb == (BASE << plane) + RST - 1, "R5", "strobe to clear",
                    cyc - last_stb, (BASE << plane) + RST - 1);
                if (!prev_clr) chk(0, "R6", "clear width", 2, 1);
            end
            prev_sclk = sclk; prev_clr = clr_n; prev_stb = strobe;
        end
    end

    task automatic idle_check(input string what);
        chk(sdo == 0 && sclk == 0 && strobe == 0 && clr_n == 1, "R9", what,
            {sdo, sclk, strobe, clr_n}, 4'b0001);
    endtask

    initial begin
        for (int j = 0; j < NCH; j++) model[j] = '0;
        repeat (5) @(negedge clk);
        idle_check("outputs in reset");
        rst_n = 1;
        @(negedge clk);
        idle_check("outputs after reset");
        // Vector walk: write during plane 1 of frame v, seen from frame v+1.
        for (int v = 0; v < NVEC; v++) begin
            wait (strobes == v * DEPTH + 2);
            @(negedge clk);
            for (int ch = 0; ch < NCH; ch++) begin
                wr_en = 1; wr_addr = 5'(ch); wr_data = vval(v, ch) | 16'h0003 & V_MASK[v];
                model[ch] = wr_data;
                @(negedge clk);
            end
            wr_en = 0;
            cur_vec = v;
            write_frame = v;
        end
        wait (strobes == (NVEC + 1) * DEPTH + 1);
        // Directed: mid-run reset clears outputs and brightness (R9).
        @(negedge clk);
        rst_n = 0;
        for (int j = 0; j < NCH; j++) model[j] = '0;
        cur_vec = -1; write_frame = -1;
        repeat (3) @(negedge clk);
        idle_check("outputs in mid-run reset");
        rst_n = 1;
        @(negedge clk);
        idle_check("outputs after mid-run reset");
        wait (strobes == 3);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule